// File: doc/BRIEF.md
# MD5 Message Padding Unit

This block sits in front of an MD5 compression core. It takes a message as a stream of bytes and turns it into complete 512-bit blocks, each one laid out as sixteen 32-bit little-endian words. After the last message byte it adds the padding marker and a run of zero bytes. It then writes the message length in bits into the final two words of the last block. Messages of any length are accepted, so a message can span as many blocks as it needs.

Bytes enter a chain of sixteen word registers. Each byte shifts in at the top word, and every word passes its low byte down to the word below it. When 64 byte shifts have filled a block, the block is offered on a valid/ready output. The byte input stays stalled until the consumer takes the block. The marker, the zero fill and the eight length bytes are shifted through the same chain, one byte per cycle.

A message is ended by a beat with `inLast` set. That beat carries a final byte unless `inEmpty` is also set. A beat with both set marks the end of a message that has no bytes at all.

Top module: `md5_pad_unit`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: Within a block, byte number j (counting from 0 in arrival order) lands in word j/4, at bits [8*(j%4)+7 : 8*(j%4)]. Word k occupies `outBlock[32k+31:32k]`.
- R3: The byte after the last message byte is 0x80. All following bytes up to block byte 56 are 0x00.
- R4: Bytes 56..63 of the final block hold the message length in bits, least significant byte first. Word 14 therefore holds the low 32 bits and word 15 the high 32 bits; a 39-byte message gives word 14 = 0x00000138.
- R5: A message that ends at block byte offset 56..63 completes that block with the marker and zeros. It then produces one more block that holds only zeros and the length.
- R6: A message whose length is a multiple of 64 bytes is followed by a block whose word 0 is 0x00000080, with zeros up to the length words.
- R7: An empty message (inLast and inEmpty on one beat) yields exactly one block: word 0 = 0x00000080 and every other word zero.
- R8: Every 64 message bytes form a block that is emitted as soon as it fills. The length field counts every byte of the message across all its blocks.
- R9: While `outValid` is 1, `inReady` is 0. `outValid` and `outBlock` stay unchanged until a cycle with `outReady` 1.
- R10: The length count restarts at zero for each new message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Message byte |
| inValid | input | 1 | Input beat present |
| inLast | input | 1 | Beat ends the message |
| inEmpty | input | 1 | With inLast: the beat carries no byte |
| inReady | output | 1 | Block accepts an input beat |
| outBlock | output | 512 | Padded block, word k at bits [32k+31:32k] |
| outValid | output | 1 | Block complete and offered |
| outReady | input | 1 | Consumer takes the block |

## Verification
The bench aims at the message lengths where padding changes shape:
- Zero bytes: a design that mishandles the empty message emits no block, or shifts a stray data byte into word 0.
- Offsets 55, 56 and 63: an off-by-one in the length threshold either writes the length over the marker or leaves the extra block out.
- Exact multiples of 64 bytes: a design that drops the marker here emits a final block whose word 0 is zero.
- Sequences of messages: these expose a length counter that is never cleared.

The output is also stalled on a fixed pattern. Any block that changes while it waits, or any input accepted during the stall, is reported.

// File: rtl/md5pad_pkg.sv
package md5pad_pkg;
  localparam int BYTE_W    = 8;
  localparam int LEN_W     = 64;
  localparam int LEN_BYTES = LEN_W / BYTE_W;
  localparam int LEN_IDX_W = $clog2(LEN_BYTES);

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_MARK = 2'd1,
    SRC_ZERO = 2'd2,
    SRC_LEN  = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic                 shiftEn;
    srcSel_e              src;
    logic [LEN_IDX_W-1:0] lenIdx;
    logic                 incLen;
    logic                 clrLen;
  } padCtrl_t;
endpackage

// File: rtl/md5pad_datapath.sv
module md5pad_datapath
  import md5pad_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  padCtrl_t                    ctrl,
  input  logic [BYTE_W-1:0]           inData,
  output logic [NUM_WORDS*WORD_W-1:0] block
);
  localparam int BLOCK_W = NUM_WORDS * WORD_W;

  logic [WORD_W-1:0] wordQ [NUM_WORDS];
  logic [LEN_W-1:0]  lenQ;
  logic [BYTE_W-1:0] newByte;

  always_comb begin
    unique case (ctrl.src)
      SRC_DATA: newByte = inData;
      SRC_MARK: newByte = BYTE_W'(8'h80);
      SRC_ZERO: newByte = '0;
      SRC_LEN:  newByte = lenQ[ctrl.lenIdx*BYTE_W +: BYTE_W];
      default:  newByte = '0;
    endcase
  end

  // Cascade: the top word takes the new byte; each word hands its low byte down.
  genvar k;
  generate
    for (k = 0; k < NUM_WORDS; k++) begin : g_word
      logic [BYTE_W-1:0] feedByte;
      if (k == NUM_WORDS - 1) begin : g_top
        assign feedByte = newByte;
      end else begin : g_mid
        assign feedByte = wordQ[k+1][BYTE_W-1:0];
      end
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wordQ[k] <= '0;
        end else if (ctrl.shiftEn) begin
          wordQ[k] <= {feedByte, wordQ[k][WORD_W-1:BYTE_W]};
        end
      end
      assign block[k*WORD_W +: WORD_W] = wordQ[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clrLen) begin
      lenQ <= '0;
    end else if (ctrl.incLen) begin
      lenQ <= lenQ + LEN_W'(BYTE_W);
    end
  end

  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.incLen && !ctrl.clrLen |=> lenQ == $past(lenQ) + LEN_W'(BYTE_W)); // R8
  AST_LEN_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrLen |=> lenQ == '0); // R10
  AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.shiftEn |=> block == $past(block)); // R9

  initial begin
    if (BLOCK_W % (BYTE_W * 8) != 0) $error("block width must be a whole number of length fields");
  end
endmodule

// File: rtl/md5pad_ctrl.sv
module md5pad_ctrl
  import md5pad_pkg::*;
#(
  parameter int BLOCK_BYTES = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     inEmpty,
  output logic     inReady,
  output logic     outValid,
  input  logic     outReady,
  output padCtrl_t ctrl
);
  localparam int POS_W     = $clog2(BLOCK_BYTES);
  localparam int LEN_START = BLOCK_BYTES - LEN_BYTES;

  typedef enum logic [1:0] {ST_MSG, ST_PAD, ST_LEN, ST_FULL} state_e;

  state_e            stateQ, stateD, resumeQ, resumeD;
  logic [POS_W-1:0]  posQ, posD;
  logic              markDoneQ, markDoneD;
  logic              lastPos;
  logic [POS_W-1:0]  lenOffset;

  assign lastPos   = (posQ == POS_W'(BLOCK_BYTES - 1));
  assign lenOffset = posQ - POS_W'(LEN_START);

  always_comb begin
    state_e after;
    stateD    = stateQ;
    resumeD   = resumeQ;
    posD      = posQ;
    markDoneD = markDoneQ;
    ctrl      = '0;
    ctrl.src  = SRC_ZERO;
    inReady   = 1'b0;
    outValid  = 1'b0;
    after     = ST_MSG;
    unique case (stateQ)
      ST_MSG: begin
        inReady = 1'b1;
        if (inValid) begin
          after = inLast ? ST_PAD : ST_MSG;
          if (inLast) markDoneD = 1'b0;
          if (!(inLast && inEmpty)) begin
            ctrl.shiftEn = 1'b1;
            ctrl.src     = SRC_DATA;
            ctrl.incLen  = 1'b1;
            posD         = posQ + 1'b1;
          end
          if (ctrl.shiftEn && lastPos) begin
            stateD  = ST_FULL;
            resumeD = after;
          end else begin
            stateD = after;
          end
        end
      end
      ST_PAD: begin
        if (markDoneQ && posQ == POS_W'(LEN_START)) begin
          stateD = ST_LEN;
        end else begin
          ctrl.shiftEn = 1'b1;
          ctrl.src     = markDoneQ ? SRC_ZERO : SRC_MARK;
          markDoneD    = 1'b1;
          posD         = posQ + 1'b1;
          if (lastPos) begin
            stateD  = ST_FULL;
            resumeD = ST_PAD;
          end
        end
      end
      ST_LEN: begin
        ctrl.shiftEn = 1'b1;
        ctrl.src     = SRC_LEN;
        ctrl.lenIdx  = lenOffset[LEN_IDX_W-1:0];
        posD         = posQ + 1'b1;
        if (lastPos) begin
          ctrl.clrLen = 1'b1;
          stateD      = ST_FULL;
          resumeD     = ST_MSG;
        end
      end
      ST_FULL: begin
        outValid = 1'b1;
        if (outReady) stateD = resumeQ;
      end
      default: stateD = ST_MSG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_MSG;
      resumeQ   <= ST_MSG;
      posQ      <= '0;
      markDoneQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      resumeQ   <= resumeD;
      posQ      <= posD;
      markDoneQ <= markDoneD;
    end
  end

  AST_FULL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> posQ == '0); // R8
  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R9
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid); // R9
  AST_LEN_AFTER_MARK: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_LEN |-> markDoneQ); // R3
  AST_LEN_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_LEN |-> posQ >= POS_W'(LEN_START)); // R4
endmodule

// File: rtl/md5_pad_unit.sv
module md5_pad_unit
  import md5pad_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [7:0]                  inData,
  input  logic                        inValid,
  input  logic                        inLast,
  input  logic                        inEmpty,
  output logic                        inReady,
  output logic [NUM_WORDS*WORD_W-1:0] outBlock,
  output logic                        outValid,
  input  logic                        outReady
);
  localparam int BLOCK_BYTES = NUM_WORDS * WORD_W / BYTE_W;

  padCtrl_t ctrl;

  md5pad_ctrl #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .inEmpty  (inEmpty),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .ctrl     (ctrl)
  );

  md5pad_datapath #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .inData (inData),
    .block  (outBlock)
  );

  AST_BLOCK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outBlock)); // R9
endmodule

// File: tb/tb_md5_pad_unit.sv
module tb_md5_pad_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC = 13;
  // Columns: message length in bytes, data seed, requirement tag number.
  localparam int VEC_LEN  [NUM_VEC] = '{0, 1, 3, 25, 39, 55, 56, 63, 64, 65, 120, 130, 200};
  localparam int VEC_SEED [NUM_VEC] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13};
  // R7, R3, R2, R3, R4, R3, R5, R5, R6, R8, R5, R8, R10
  localparam int VEC_TAG  [NUM_VEC] = '{7, 3, 2, 3, 4, 3, 5, 5, 6, 8, 5, 8, 10};

  logic         clk = 1'b0;
  logic         rstN;
  logic [7:0]   inData;
  logic         inValid, inLast, inEmpty, inReady;
  logic [511:0] outBlock;
  logic         outValid, outReady;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  md5_pad_unit dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inEmpty(inEmpty), .inReady(inReady), .outBlock(outBlock), .outValid(outValid),
    .outReady(outReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] msgByte(input int seed, input int i);
    return 8'(seed * 7 + i * 13 + 1);
  endfunction

  function automatic logic [7:0] padByte(input int len, input int seed, input int idx, input int total);
    logic [63:0] bits;
    bits = 64'(len) * 64'd8;
    if (idx < len) return msgByte(seed, idx);
    if (idx == len) return 8'h80;
    if (idx >= total - 8) return bits[(idx - (total - 8)) * 8 +: 8];
    return 8'h00;
  endfunction

  task automatic sendBeat(input logic [7:0] d, input logic last, input logic empty);
    @(negedge clk);
    inValid = 1'b1; inData = d; inLast = last; inEmpty = empty;
    while (!inReady) @(negedge clk);
  endtask

  task automatic sendMsg(input int len, input int seed);
    if (len == 0) sendBeat(8'h00, 1'b1, 1'b1);
    for (int i = 0; i < len; i++) sendBeat(msgByte(seed, i), i == len - 1, 1'b0);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inEmpty = 1'b0;
  endtask

  task automatic recvMsg(input int len, input int seed, input int tagN);
    int nBlk;
    int b;
    bit holding;
    logic [511:0] held;
    logic [511:0] exp;
    nBlk = (len + 8) / 64 + 1;
    b = 0;
    holding = 1'b0;
    held = '0;
    while (b < nBlk) begin
      @(negedge clk);
      cyc++;
      if (holding) begin
        chk(outValid && outBlock == held && !inReady, "R9", "stalled block held", outBlock, held);
      end
      outReady = (cyc % 3) != 0;
      if (outValid) begin
        if (outReady) begin
          for (int k = 0; k < 64; k++) exp[8*k +: 8] = padByte(len, seed, 64*b + k, 64*nBlk);
          chk(outBlock == exp, $sformatf("R%0d", tagN),
              $sformatf("len %0d block %0d", len, b), outBlock, exp);
          b++;
          holding = 1'b0;
        end else begin
          holding = 1'b1;
          held = outBlock;
        end
      end
    end
    @(negedge clk);
    outReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] expB;
    rstN = 1'b0; inData = '0; inValid = 1'b0; inLast = 1'b0; inEmpty = 1'b0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid after reset", 512'(outValid), 512'(0));
    chk(inReady == 1'b1, "R1", "inReady after reset", 512'(inReady), 512'(1));

    // Directed R2: byte order within words, marker position, length word.
    fork
      begin
        sendBeat(8'h11, 1'b0, 1'b0);
        sendBeat(8'h22, 1'b0, 1'b0);
        sendBeat(8'h33, 1'b0, 1'b0);
        sendBeat(8'h44, 1'b0, 1'b0);
        sendBeat(8'h55, 1'b1, 1'b0);
        @(negedge clk);
        inValid = 1'b0; inLast = 1'b0;
      end
      begin
        @(negedge clk);
        while (!outValid) @(negedge clk);
        expB = '0;
        expB[31:0]    = 32'h44332211;
        expB[63:32]   = 32'h00008055;
        expB[479:448] = 32'd40;
        chk(outBlock == expB, "R2", "little-endian packing", outBlock, expB);
        chk(inReady == 1'b0, "R9", "input stalled while block waits", 512'(inReady), 512'(0));
        outReady = 1'b1;
        @(negedge clk);
        outReady = 1'b0;
        chk(outValid == 1'b0, "R9", "valid drops after accept", 512'(outValid), 512'(0));
      end
    join

    for (int v = 0; v < NUM_VEC; v++) begin
      fork
        sendMsg(VEC_LEN[v], VEC_SEED[v]);
        recvMsg(VEC_LEN[v], VEC_SEED[v], VEC_TAG[v]);
      join
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule